// File: doc/BRIEF.md
# Bridge Driver Fault Supervisor

This block watches over the eight output transistors of a two-coil (X and Y) full-bridge motor driver. It takes a thermal-warning comparator, a thermal-shutdown comparator and one over-current comparator per transistor. From these it builds three status words and one enable line per transistor. Every comparator input first passes through a two-stage synchronizer. Over-current events and thermal shutdown are then held in sticky flags. While any sticky flag is set, every transistor enable is pulled low so the bridge floats.

A status read arrives from the serial shell as a one-cycle strobe. In the strobe cycle the status word still shows its current contents, so a held event is always reported once. At the end of that cycle the word's sticky flags clear, unless the condition that set them is still present. The thermal shutdown flag has a stricter rule: it clears only when its word is read while the synchronized warning comparator is low. The warning bit itself is live status and never latches.

Top module: `fault_diag_top`

## Requirements
- R1: A comparator input passes through two synchronizer flops. The warning bit follows the input two clock edges after the input changes. A sticky flag sets on the third edge after its input first goes high, so a one-cycle input pulse is still captured.
- R2: Status word 0 bit 0 is the synchronized warning comparator. It rises and falls with that comparator without any read. All other bits of word 0 read zero.
- R3: Status word 1 bits 3:0 hold the sticky over-current flags of X transistors 0 to 3, with bit i for transistor i. Bits 7:4 read zero. A flag stays set until word 1 is read.
- R4: Status word 2 bits 3:0 hold the sticky over-current flags of Y transistors 0 to 3. Bit 4 holds the sticky thermal shutdown flag. Bits 7:5 read zero.
- R5: A read strobe on word 1 clears the X flags at the end of the strobe cycle and leaves word 2 untouched. A read strobe on word 2 clears the Y flags and does not change word 1.
- R6: If a flag's synchronized condition is still high in the cycle of the clearing read, the flag stays set.
- R7: During the strobe cycle the word shows its contents from before the clear.
- R8: A word 2 read clears the shutdown flag only if the synchronized warning is low in that cycle. If the warning is high, the flag stays set.
- R9: Enable bits 3:0 drive X transistors 0 to 3 and bits 7:4 drive Y transistors 0 to 3. All eight are low while any over-current flag or the shutdown flag is set, and all eight are high otherwise.
- R10: After reset all status words are zero and all enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tw_cmp_i | input | 1 | Thermal warning comparator, asynchronous |
| tsd_cmp_i | input | 1 | Thermal shutdown comparator, asynchronous |
| ovc_x_cmp_i | input | 4 | Over-current comparators, X coil transistors |
| ovc_y_cmp_i | input | 4 | Over-current comparators, Y coil transistors |
| rd_sr1_i | input | 1 | Read strobe for status word 1, one cycle |
| rd_sr2_i | input | 1 | Read strobe for status word 2, one cycle |
| sr0_o | output | 8 | Status word 0: live warning |
| sr1_o | output | 8 | Status word 1: X over-current flags |
| sr2_o | output | 8 | Status word 2: Y over-current flags and shutdown flag |
| drv_en_o | output | 8 | Per-transistor enables |

## Verification
The bench builds the block with its default values: four transistors per coil, two synchronizer stages and eight-bit status words. With these values the bit positions named in the requirements are fixed. Every sticky flag can be exercised against the three-edge capture latency. A read that lands while its condition is still active can be timed exactly. The shutdown flag can be held set by a warm read and then released by a cool one. Directed sequences pin down these corners. A long random phase with an asynchronous reset in the middle is then compared cycle by cycle against a queue-based model.

// File: rtl/fdl_pkg.sv
package fdl_pkg;
    localparam int unsigned NUM_COILS  = 2;
    localparam int unsigned COIL_X_IDX = 0;
    localparam int unsigned COIL_Y_IDX = 1;
endpackage

// File: rtl/fdl_sync.sv
module fdl_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fdl_ovc_bank.sv
module fdl_ovc_bank #(
    parameter int unsigned N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] evt_i,
    input  logic         clr_i,
    output logic [N-1:0] lat_o
);
    typedef struct packed {
        logic [N-1:0] lat;
    } bank_t;

    bank_t bank_d, bank_q;

    // A live event wins over a clearing read in the same cycle.
    always_comb begin
        bank_d     = bank_q;
        bank_d.lat = (bank_q.lat & ~{N{clr_i}}) | evt_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign lat_o = bank_q.lat;
endmodule

// File: rtl/fault_diag_top.sv
module fault_diag_top
    import fdl_pkg::*;
#(
    parameter int unsigned OVC_PER_COIL = 4,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned REG_W        = 8
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             tw_cmp_i,
    input  logic                             tsd_cmp_i,
    input  logic [OVC_PER_COIL-1:0]          ovc_x_cmp_i,
    input  logic [OVC_PER_COIL-1:0]          ovc_y_cmp_i,
    input  logic                             rd_sr1_i,
    input  logic                             rd_sr2_i,
    output logic [REG_W-1:0]                 sr0_o,
    output logic [REG_W-1:0]                 sr1_o,
    output logic [REG_W-1:0]                 sr2_o,
    output logic [NUM_COILS*OVC_PER_COIL-1:0] drv_en_o
);
    localparam int unsigned NUM_DRV = NUM_COILS * OVC_PER_COIL;
    localparam int unsigned SYNC_W  = NUM_DRV + 2;
    localparam int unsigned PAD1_W  = REG_W - OVC_PER_COIL;
    localparam int unsigned PAD2_W  = REG_W - OVC_PER_COIL - 1;

    typedef struct packed {
        logic tsd;
    } state_t;

    state_t state_d, state_q;

    logic [SYNC_W-1:0]       raw_vec;
    logic [SYNC_W-1:0]       sync_vec;
    logic [OVC_PER_COIL-1:0] ovc_x_s;
    logic [OVC_PER_COIL-1:0] ovc_y_s;
    logic                    tsd_s;
    logic                    tw_s;
    logic [OVC_PER_COIL-1:0] lat [NUM_COILS];
    logic                    fault_any;

    assign raw_vec = {tw_cmp_i, tsd_cmp_i, ovc_y_cmp_i, ovc_x_cmp_i};

    fdl_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_vec),
        .q_o    (sync_vec)
    );

    assign ovc_x_s = sync_vec[OVC_PER_COIL-1:0];
    assign ovc_y_s = sync_vec[NUM_DRV-1:OVC_PER_COIL];
    assign tsd_s   = sync_vec[NUM_DRV];
    assign tw_s    = sync_vec[NUM_DRV+1];

    for (genvar c = 0; c < NUM_COILS; c++) begin : g_coil
        logic                    clr;
        logic [OVC_PER_COIL-1:0] evt;
        if (c == COIL_X_IDX) begin : g_x
            assign clr = rd_sr1_i;
            assign evt = ovc_x_s;
        end else begin : g_y
            assign clr = rd_sr2_i;
            assign evt = ovc_y_s;
        end
        fdl_ovc_bank #(
            .N (OVC_PER_COIL)
        ) u_bank (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .evt_i  (evt),
            .clr_i  (clr),
            .lat_o  (lat[c])
        );
    end

    // Shutdown flag: set by the synchronized comparator, cleared only by a
    // word-2 read taken while the warning comparator is low.
    always_comb begin
        state_d     = state_q;
        state_d.tsd = tsd_s | (state_q.tsd & ~(rd_sr2_i & ~tw_s));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign fault_any = state_q.tsd | (|lat[COIL_X_IDX]) | (|lat[COIL_Y_IDX]);

    assign sr0_o    = {{(REG_W-1){1'b0}}, tw_s};
    assign sr1_o    = {{PAD1_W{1'b0}}, lat[COIL_X_IDX]};
    assign sr2_o    = {{PAD2_W{1'b0}}, state_q.tsd, lat[COIL_Y_IDX]};
    assign drv_en_o = {NUM_DRV{~fault_any}};
endmodule

// File: rtl/fdl_checker.sv
module fdl_checker #(
    parameter int unsigned OVC_PER_COIL = 4,
    parameter int unsigned REG_W        = 8,
    parameter int unsigned NUM_DRV      = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               rd_sr1_i,
    input logic               rd_sr2_i,
    input logic [REG_W-1:0]   sr0_o,
    input logic [REG_W-1:0]   sr1_o,
    input logic [REG_W-1:0]   sr2_o,
    input logic [NUM_DRV-1:0] drv_en_o
);
    localparam int unsigned TSD_POS = OVC_PER_COIL;

    p_sr0_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sr0_o[REG_W-1:1] == '0);

    p_x_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_sr1_i |=> ((sr1_o & $past(sr1_o)) == $past(sr1_o)));

    p_y_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_sr2_i |=> ((sr2_o & $past(sr2_o)) == $past(sr2_o)));

    p_tsd_warm_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sr2_o[TSD_POS] && sr0_o[0]) |=> sr2_o[TSD_POS]);

    p_en_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|sr1_o) || (|sr2_o)) |-> (drv_en_o == '0));

    p_en_on_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((sr1_o == '0) && (sr2_o == '0)) |-> (&drv_en_o));
endmodule

bind fault_diag_top fdl_checker #(
    .OVC_PER_COIL (OVC_PER_COIL),
    .REG_W        (REG_W),
    .NUM_DRV      (NUM_DRV)
) u_fdl_checker (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_sr1_i (rd_sr1_i),
    .rd_sr2_i (rd_sr2_i),
    .sr0_o    (sr0_o),
    .sr1_o    (sr1_o),
    .sr2_o    (sr2_o),
    .drv_en_o (drv_en_o)
);

// File: tb/fault_diag_top_tb_top.sv
`timescale 1ns/1ps
module fault_diag_top_tb_top;
    localparam int N      = 4;
    localparam int STAGES = 2;
    localparam int W      = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tw = 1'b0, tsd = 1'b0, rd1 = 1'b0, rd2 = 1'b0;
    logic [N-1:0] ox = '0, oy = '0;
    logic [W-1:0] sr0, sr1, sr2;
    logic [7:0]   en;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  started = 1'b0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    fault_diag_top dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tw_cmp_i    (tw),
        .tsd_cmp_i   (tsd),
        .ovc_x_cmp_i (ox),
        .ovc_y_cmp_i (oy),
        .rd_sr1_i    (rd1),
        .rd_sr2_i    (rd2),
        .sr0_o       (sr0),
        .sr1_o       (sr1),
        .sr2_o       (sr2),
        .drv_en_o    (en)
    );

    // Reference model: sample history queue plus sticky flags.
    logic [9:0] hist[$];
    logic [3:0] m_x = '0, m_y = '0;
    logic       m_tsd = 1'b0;

    function automatic logic [9:0] synced();
        if (hist.size() >= STAGES) return hist[hist.size()-STAGES];
        return '0;
    endfunction

    always @(posedge clk) begin
        logic [9:0] sv;
        started <= 1'b1;
        if (!rst_n) begin
            m_x = '0; m_y = '0; m_tsd = 1'b0;
            hist.delete();
        end else begin
            sv = synced();
            m_x   = (rd1 ? 4'b0 : m_x) | sv[3:0];
            m_y   = (rd2 ? 4'b0 : m_y) | sv[7:4];
            m_tsd = sv[8] | (m_tsd & !(rd2 && !sv[9]));
            hist.push_back({tw, tsd, oy, ox});
            if (hist.size() > 8) void'(hist.pop_front());
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic [W-1:0] e0, e1, e2;
        logic [7:0]   ee;
        if (started && !done) begin
            e0 = {7'b0, synced() >> 9};
            e1 = {4'b0, m_x};
            e2 = {3'b0, m_tsd, m_y};
            ee = (m_x != 0 || m_y != 0 || m_tsd) ? 8'h00 : 8'hFF;
            chk(sr0 === e0, "R2 word0", sr0, e0);
            chk(sr1 === e1, "R3 word1", sr1, e1);
            chk(sr2 === e2, "R4 word2", sr2, e2);
            chk(en === ee, "R9 enables", en, ee);
        end
    end

    task automatic adv(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        adv(3);
        #1 rst_n = 1'b1;
        adv(0);
        // R10 reset state
        chk(sr0 == 0 && sr1 == 0 && sr2 == 0, "R10 status", {sr2, sr1, sr0}, 0);
        chk(en == 8'hFF, "R10 enables", en, 8'hFF);

        // R1: one-cycle pulse on X transistor 2
        #1 ox = 4'b0100;
        adv(1);
        #1 ox = '0;
        adv(1);
        chk(sr1 == 8'h00, "R1 not yet", sr1, 0);
        adv(1);
        chk(sr1 == 8'h04, "R1 captured", sr1, 4);
        chk(en == 8'h00, "R9 off", en, 0);

        // R7 then R5: read word 1
        #1 rd1 = 1'b1;
        #1 chk(sr1 == 8'h04, "R7 pre-clear", sr1, 4);
        adv(1);
        chk(sr1 == 8'h00, "R5 x cleared", sr1, 0);
        chk(en == 8'hFF, "R9 on", en, 8'hFF);
        #1 rd1 = 1'b0;

        // R5: word-1 read leaves Y flags
        #1 ox = 4'b0001; oy = 4'b0010;
        adv(1);
        #1 ox = '0; oy = '0;
        adv(2);
        chk(sr1 == 8'h01 && sr2 == 8'h02, "R5 both set", {sr2, sr1}, 16'h0201);
        #1 rd1 = 1'b1;
        adv(1);
        chk(sr1 == 8'h00 && sr2 == 8'h02, "R5 y kept", {sr2, sr1}, 16'h0200);
        chk(en == 8'h00, "R9 still off", en, 0);
        #1 rd1 = 1'b0; rd2 = 1'b1;
        adv(1);
        chk(sr2 == 8'h00, "R5 y cleared", sr2, 0);
        #1 rd2 = 1'b0;

        // R6: read while condition persists
        #1 oy = 4'b1000;
        adv(3);
        chk(sr2 == 8'h08, "R6 set", sr2, 8);
        #1 rd2 = 1'b1;
        adv(1);
        chk(sr2 == 8'h08, "R6 set wins", sr2, 8);
        #1 rd2 = 1'b0; oy = '0;
        adv(3);
        #1 rd2 = 1'b1;
        adv(1);
        chk(sr2 == 8'h00, "R6 later clear", sr2, 0);
        #1 rd2 = 1'b0;

        // R8: shutdown needs cool read
        #1 tw = 1'b1; tsd = 1'b1;
        adv(1);
        #1 tsd = 1'b0;
        adv(3);
        chk(sr2 == 8'h10, "R8 tsd set", sr2, 8'h10);
        chk(sr0 == 8'h01, "R2 warn live", sr0, 1);
        #1 rd2 = 1'b1;
        #1 chk(sr2 == 8'h10, "R7 word2 pre-clear", sr2, 8'h10);
        adv(1);
        chk(sr2 == 8'h10, "R8 warm read keeps", sr2, 8'h10);
        #1 rd2 = 1'b0; tw = 1'b0;
        adv(2);
        chk(sr0 == 8'h00, "R2 warn falls", sr0, 0);
        chk(sr2 == 8'h10, "R8 no read no clear", sr2, 8'h10);
        #1 rd2 = 1'b1;
        adv(1);
        chk(sr2 == 8'h00, "R8 cool read clears", sr2, 0);
        chk(en == 8'hFF, "R9 restored", en, 8'hFF);
        #1 rd2 = 1'b0;

        // Random phase, compared every cycle by the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            #1;
            if (i == 1500) rst_n = 1'b0;
            if (i == 1503) rst_n = 1'b1;
            if ($urandom % 16 == 0) tw = ~tw;
            tsd = ($urandom % 64 == 0);
            ox  = ($urandom % 20 == 0) ? 4'($urandom) : 4'b0;
            oy  = ($urandom % 20 == 0) ? 4'($urandom) : 4'b0;
            rd1 = ($urandom % 6 == 0);
            rd2 = ($urandom % 6 == 0);
        end
        adv(1);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule